// File: doc/BRIEF.md
# GPIO Pad Control Bank

This block is a register-mapped general-purpose I/O controller. It serves a configurable number of ports, with eight pins in each port, behind a simple 32-bit register bus. For every pin, software chooses one of four drive styles and sets an output data bit and a pull-up disable bit. From these the block produces three pad signals for each pin: an output level, an output enable and a pull-up enable. Pad input levels pass through a two-stage synchroniser before software can read them.

Each port owns an address window at a fixed stride of 0x30 bytes. A shared control word sits at address 0x00. It holds two writable control bits next to read-only fields that report the port count and a version number. Read data comes back one clock after the request and is zero in every cycle that has no read.

Top module: `gpio_pad_bank`

## Requirements
- R1: After synchronous reset, every register bit that software can write is zero. Every pin then has pad_oe=0 and pad_out=0, and its pull-up is enabled (pad_pu_en=1).
- R2: Port n decodes addresses n*0x30 + offset. Offset 0x08 is output data (bits [7:0], read/write). Offset 0x0C is the drive mode (bits [15:0], two bits per pin at bit 2*b, read/write). Offset 0x10 is the pull-up disable (bits [7:0], read/write). A write to one port never changes another port.
- R3: The control word at address 0x00 has clock request in bit 0 and synchroniser select in bit 1, both read/write, and driven on ctl_clk_req and ctl_sync_sel. Bits [8:2] read the VERSION_ID parameter and bits [15:9] read NUM_PORTS. Writes leave these read-only fields unchanged.
- R4: Drive code 01 (push-pull) gives pad_oe=1 and pad_out equal to the pin's output data bit.
- R5: Drive code 10 (open-drain) gives pad_out=0 and pad_oe equal to the inverse of the output data bit.
- R6: Drive code 11 (open-source) gives pad_out=1 and pad_oe equal to the output data bit.
- R7: Drive code 00 (input) gives pad_oe=0 and pad_out=0.
- R8: pad_pu_en for a pin is the inverse of its pull-up disable bit.
- R9: Offset 0x04 of port n reads pad_in[8n+7:8n] through two flops. A read whose request is sampled on the first or second rising edge after a pad change returns the old level. A read sampled on the third edge returns the new level. Writes to offset 0x04 are ignored.
- R10: Reads of offset 0x00 of ports other than 0, of offsets outside 0x04–0x10, or of addresses beyond the last port return zero, and writes to them change nothing. bus_rdata is registered, with the data one cycle after the read request, and is zero after any cycle with no read.
- R11: Pad vector bit 8n+b belongs to pin b of port n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad output levels |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| pad_pu_en | output | 8*NUM_PORTS | Pad pull-up enables |
| ctl_clk_req | output | 1 | Control bit 0 |
| ctl_sync_sel | output | 1 | Control bit 1 |

## Verification
The pad outputs depend only on register state through combinational logic. A corrupted output data, drive mode or pull-up bit therefore shows on pad_out, pad_oe or pad_pu_en in the cycle right after the write. A decode fault that lands a write in the wrong port or offset shows on the victim port's pads, or in a later read-back, within two cycles. A synchroniser that is too short or too long moves the cycle in which the new input level first reads back, so reads in the second and third cycles after a pad change separate those faults.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_PORT = 8;
    localparam int MODE_W        = 2 * PINS_PER_PORT;
    localparam int PORT_STRIDE   = 48;
    localparam int OFS_W         = $clog2(PORT_STRIDE);

    localparam logic [OFS_W-1:0] OFS_CTRL  = OFS_W'(8'h00);
    localparam logic [OFS_W-1:0] OFS_IN    = OFS_W'(8'h04);
    localparam logic [OFS_W-1:0] OFS_DOUT  = OFS_W'(8'h08);
    localparam logic [OFS_W-1:0] OFS_MODE  = OFS_W'(8'h0C);
    localparam logic [OFS_W-1:0] OFS_PUDIS = OFS_W'(8'h10);

    typedef enum logic [1:0] {
        MODE_INPUT       = 2'b00,
        MODE_PUSH_PULL   = 2'b01,
        MODE_OPEN_DRAIN  = 2'b10,
        MODE_OPEN_SOURCE = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [PINS_PER_PORT-1:0] dout;
        logic [MODE_W-1:0]        mode;
        logic [PINS_PER_PORT-1:0] pudis;
    } port_cfg_t;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drv_t;

    function automatic pad_drv_t drive_of(pin_mode_e m, logic d);
        pad_drv_t r;
        case (m)
            MODE_PUSH_PULL:   begin r.out = d;    r.oe = 1'b1; end
            MODE_OPEN_DRAIN:  begin r.out = 1'b0; r.oe = ~d;   end
            MODE_OPEN_SOURCE: begin r.out = 1'b1; r.oe = d;    end
            default:          begin r.out = 1'b0; r.oe = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [15:0]      wdata,
    output port_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_DOUT:  cfg.dout  <= wdata[PINS_PER_PORT-1:0];
                OFS_MODE:  cfg.mode  <= wdata[MODE_W-1:0];
                OFS_PUDIS: cfg.pudis <= wdata[PINS_PER_PORT-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
(
    input  port_cfg_t                cfg,
    output logic [PINS_PER_PORT-1:0] pad_out,
    output logic [PINS_PER_PORT-1:0] pad_oe,
    output logic [PINS_PER_PORT-1:0] pad_pu_en
);
    for (genvar b = 0; b < PINS_PER_PORT; b++) begin : g_pin
        pad_drv_t drv;
        assign drv          = drive_of(pin_mode_e'(cfg.mode[2*b +: 2]), cfg.dout[b]);
        assign pad_out[b]   = drv.out;
        assign pad_oe[b]    = drv.oe;
        assign pad_pu_en[b] = ~cfg.pudis[b];
    end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS  = 7,
    parameter int VERSION_ID = 3,
    parameter int ADDR_W     = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               bus_sel,
    input  logic                               bus_wr,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [31:0]                        bus_wdata,
    output logic [31:0]                        bus_rdata,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pu_en,
    output logic                               ctl_clk_req,
    output logic                               ctl_sync_sel
);
    localparam int NPINS = NUM_PORTS * PINS_PER_PORT;
    localparam logic [6:0] CORES_FIELD = 7'(NUM_PORTS);
    localparam logic [6:0] VER_FIELD   = 7'(VERSION_ID);

    logic             rd_req, wr_req, ctrl_hit;
    logic [1:0]       ctrl_q;
    logic [31:0]      ctrl_word, rd_mux;
    logic [NPINS-1:0] sync_in;
    port_cfg_t        cfg     [NUM_PORTS];
    logic [31:0]      port_rd [NUM_PORTS];
    logic             unused_wdata_hi;

    assign rd_req          = bus_sel && !bus_wr;
    assign wr_req          = bus_sel && bus_wr;
    assign ctrl_hit        = (bus_addr == '0);
    assign unused_wdata_hi = ^bus_wdata[31:16];

    // shared control word
    always_ff @(posedge clk) begin
        if (rst)                     ctrl_q <= '0;
        else if (wr_req && ctrl_hit) ctrl_q <= bus_wdata[1:0];
    end
    assign ctl_clk_req  = ctrl_q[0];
    assign ctl_sync_sel = ctrl_q[1];
    assign ctrl_word    = {16'h0, CORES_FIELD, VER_FIELD, ctrl_q};

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(p * PORT_STRIDE);
        logic [ADDR_W-1:0] rel;
        logic              hit;
        logic [OFS_W-1:0]  port_ofs;
        logic [31:0]       rd_word;

        assign rel      = bus_addr - LO;
        assign hit      = rel < ADDR_W'(PORT_STRIDE);
        assign port_ofs = rel[OFS_W-1:0];

        gpio_port_regs u_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_req && hit),
            .ofs   (port_ofs),
            .wdata (bus_wdata[15:0]),
            .cfg   (cfg[p])
        );

        gpio_pad_drive u_drv (
            .cfg       (cfg[p]),
            .pad_out   (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_oe    (pad_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_pu_en (pad_pu_en[p*PINS_PER_PORT +: PINS_PER_PORT])
        );

        always_comb begin
            rd_word = '0;
            if (hit) begin
                case (port_ofs)
                    OFS_IN:    rd_word[PINS_PER_PORT-1:0] = sync_in[p*PINS_PER_PORT +: PINS_PER_PORT];
                    OFS_DOUT:  rd_word[PINS_PER_PORT-1:0] = cfg[p].dout;
                    OFS_MODE:  rd_word[MODE_W-1:0]        = cfg[p].mode;
                    OFS_PUDIS: rd_word[PINS_PER_PORT-1:0] = cfg[p].pudis;
                    default:   rd_word = '0;
                endcase
            end
        end
        assign port_rd[p] = rd_word;

        for (genvar b = 0; b < PINS_PER_PORT; b++) begin : g_chk
            localparam int I = p * PINS_PER_PORT + b;
            logic [1:0] m;
            assign m = cfg[p].mode[2*b +: 2];

            // R7
            input_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
                (m == MODE_INPUT) |-> !pad_oe[I]);
            // R5
            open_drain_low_chk: assert property (@(posedge clk) disable iff (rst)
                (m == MODE_OPEN_DRAIN) |-> !pad_out[I]);
            // R6
            open_source_high_chk: assert property (@(posedge clk) disable iff (rst)
                (m == MODE_OPEN_SOURCE) |-> pad_out[I]);
        end
    end

    always_comb begin
        rd_mux = ctrl_hit ? ctrl_word : '0;
        for (int p = 0; p < NUM_PORTS; p++) rd_mux |= port_rd[p];
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_pu_en == '1));
    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (bus_rdata == '0));
    // R3
    ctrl_ro_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ctrl_hit) |=> (bus_rdata[15:2] == {CORES_FIELD, VER_FIELD}));
endmodule

// File: tb/sim_gpio_pad_bank.sv
module sim_gpio_pad_bank;
    localparam int NP    = 7;
    localparam int VER   = 3;
    localparam int AW    = 10;
    localparam int NPINS = NP * 8;
    localparam logic [31:0] CTRL_RO = (32'(NP) << 9) | (32'(VER) << 2);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0, bus_rdata;
    logic [NPINS-1:0] pad_in = '0, pad_out, pad_oe, pad_pu_en;
    logic             ctl_clk_req, ctl_sync_sel;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_pad_bank #(.NUM_PORTS(NP), .VERSION_ID(VER), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en),
        .ctl_clk_req(ctl_clk_req), .ctl_sync_sel(ctl_sync_sel)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: compares read data one cycle after each sampled read request
    initial begin
        forever begin
            bit issued;
            @(posedge clk);
            issued = bus_sel && !bus_wr && !rst;
            @(negedge clk);
            if (issued && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", 32'(pad_oe[31:0]), 32'h0);
        chk("R1 out", 32'(pad_out[31:0]), 32'h0);
        chk("R1 pull-up", 32'(pad_pu_en[31:0]), 32'hFFFF_FFFF);
        bus_read(10'h000, CTRL_RO, "R1 R3 control reset");
        bus_read(10'h06C, 32'h0, "R1 port2 mode reset");

        // R3 control bits
        bus_write(10'h000, 32'hFFFF_FFFF);
        chk("R3 ctl outputs", {30'h0, ctl_sync_sel, ctl_clk_req}, 32'h3);
        bus_read(10'h000, CTRL_RO | 32'h3, "R3 read-only fields");
        bus_write(10'h030, 32'h0);  // port1 offset 0 is not the control word
        bus_read(10'h000, CTRL_RO | 32'h3, "R2 R10 port1 ofs0 miss");

        // R4 push-pull on port 3
        bus_write(10'h098, 32'h0000_00A5);
        bus_write(10'h09C, 32'hFFFF_5555);
        chk("R4 R11 oe", 32'(pad_oe[31:24]), 32'hFF);
        chk("R4 R11 out", 32'(pad_out[31:24]), 32'hA5);
        chk("R2 port2 untouched", 32'(pad_oe[23:16]), 32'h0);
        bus_read(10'h098, 32'hA5, "R2 dout readback");
        bus_read(10'h09C, 32'h5555, "R2 mode readback");

        // R5 open-drain
        bus_write(10'h09C, 32'h0000_AAAA);
        chk("R5 oe", 32'(pad_oe[31:24]), 32'h5A);
        chk("R5 out", 32'(pad_out[31:24]), 32'h00);

        // R6 open-source
        bus_write(10'h09C, 32'h0000_FFFF);
        chk("R6 oe", 32'(pad_oe[31:24]), 32'hA5);
        chk("R6 out", 32'(pad_out[31:24]), 32'hFF);

        // mixed modes on port 0: pin0 PP, pin1 OD, pin2 OS, pin3.. input
        bus_write(10'h008, 32'h06);
        bus_write(10'h00C, 32'h39);
        chk("R7 R4 R5 R6 mixed oe", 32'(pad_oe[7:0]), 32'h05);
        chk("R7 R4 R5 R6 mixed out", 32'(pad_out[7:0]), 32'h04);

        // R8 pull-up disable on port 6
        bus_write(10'h130, 32'h3C);
        chk("R8 pu_en", 32'(pad_pu_en[55:48]), 32'hC3);
        bus_read(10'h130, 32'h3C, "R8 pudis readback");

        // R9 synchronised input on port 5
        @(negedge clk);
        pad_in[47:40] = 8'h9B;
        bus_read(10'h0F4, 32'h0, "R9 second edge still old");
        bus_read(10'h0F4, 32'h9B, "R9 new level visible");
        bus_write(10'h0F4, 32'hFF);
        bus_read(10'h0F4, 32'h9B, "R9 input write ignored");

        // R10 unused offsets and addresses
        bus_write(10'h044, 32'hFFFF_FFFF);
        bus_write(10'h150, 32'hFFFF_FFFF);
        chk("R10 port1 pads unchanged", 32'(pad_oe[15:8]), 32'h0);
        chk("R10 port1 pull-ups unchanged", 32'(pad_pu_en[15:8]), 32'hFF);
        bus_read(10'h044, 32'h0, "R10 unused offset");
        bus_read(10'h150, 32'h0, "R10 beyond last port");
        bus_read(10'h3FF, 32'h0, "R10 top address");
        @(negedge clk);
        chk("R10 idle rdata zero", bus_rdata, 32'h0);

        // R1 re-reset clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 oe after re-reset", 32'(pad_oe[31:0]), 32'h0);
        bus_read(10'h098, 32'h0, "R1 dout after re-reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule